// File: doc/BRIEF.md
# Parallel Bus Cycle Master (8-bit, memory and I/O)

This block runs single read and write transfers on an 8-bit parallel system bus with separate memory and I/O address spaces. The local side presents a request together with a direction, a space select, an address and write data. Once the request is taken, the block runs one complete bus cycle. It pulses the address-latch strobe while the address goes out, then asserts exactly one of four active-low command strobes. When the cycle ends it returns the read data together with a one-clock done pulse.

The base cycle is four bus clocks. The third clock is the sampling point for a channel-ready input. A low ready there, or in any wait clock, inserts another wait clock before the final clock. The number of wait clocks is capped. Once the cap is reached the cycle finishes anyway and a timeout flag accompanies the done pulse. Memory cycles drive the full 20-bit address. I/O cycles drive only the low 16 bits, and the upper lines are held at zero.

Top module: `isa_bus_master`

## Requirements
- R1: While reset is held and after it is released, the idle bus has all four command strobes high, the address-latch strobe low, the data output enable low, and busy, done and timeout low.
- R2: A request is taken only when the block is idle. A request raised while a cycle is running has no effect: the address on the bus does not change, and no further cycle follows the current one.
- R3: In the first clock of a cycle the address-latch strobe is high and the address is on the bus, with no command strobe asserted. The latch strobe is low in every other clock.
- R4: From the second clock through the final clock, exactly one strobe is low, chosen by space and direction: memory read, memory write, I/O read or I/O write. In the first clock and when idle, none is low.
- R5: A memory cycle drives all 20 address bits. An I/O cycle drives only the low 16 bits, with bits 19..16 at zero.
- R6: When ready is high at the end of the third clock, the cycle lasts exactly four clocks, and done rises in the clock after the fourth.
- R7: When ready is low at the end of the third clock, or at the end of a wait clock, one more wait clock is inserted before the final clock, with the strobe still asserted. Ready high at the end of a wait clock leads straight to the final clock.
- R8: At most 6 wait clocks are inserted. If ready is still low at the end of the sixth wait clock, the final clock follows, and the timeout flag is high together with the done pulse. Otherwise the timeout flag is low with done.
- R9: On a write, the data output enable is high and the write data is on the bus from the second clock through the final clock. On a read, the enable stays low.
- R10: The bus input is captured at the end of the final clock of a read. It appears on the read-data output with a done pulse one clock long, and it holds its value through later write cycles.
- R11: A request presented in the clock where done is high is taken, and its first clock follows immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Cycle request, sampled only when idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| io_i | input | 1 | 1 = I/O space, 0 = memory space |
| addr_i | input | 20 | Transfer address |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | A cycle is running |
| done_o | output | 1 | One-clock pulse after the final clock |
| timeout_o | output | 1 | Wait cap reached; valid with done |
| rdata_o | output | 8 | Data from the last read |
| bus_addr_o | output | 20 | Bus address lines |
| bus_ale_o | output | 1 | Address-latch strobe |
| bus_memr_n_o | output | 1 | Memory read strobe, active low |
| bus_memw_n_o | output | 1 | Memory write strobe, active low |
| bus_ior_n_o | output | 1 | I/O read strobe, active low |
| bus_iow_n_o | output | 1 | I/O write strobe, active low |
| bus_dout_o | output | 8 | Data driven to the bus |
| bus_doe_o | output | 1 | Data output enable |
| bus_din_i | input | 8 | Data read from the bus |
| bus_rdy_i | input | 1 | Channel ready; low stretches the cycle |

## Verification
The bench builds the block with its default parameters: a 20-bit memory address, a 16-bit I/O address, an 8-bit data bus and a cap of six wait clocks. With a cap that small, the timeout path is reached by holding ready low for seven sample points, and the bench draws stall lengths from zero to eight. Those lengths cover no wait, every wait count below the cap, the cycle that ends exactly at the cap, and the cycle that overruns it.

// File: rtl/isab_pkg.sv
package isab_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_CMD  = 3'd2,
    PH_SAMP = 3'd3,
    PH_WAIT = 3'd4,
    PH_LAST = 3'd5
  } phase_t;

  typedef struct packed {
    logic io;
    logic wr;
  } cmd_t;

  localparam int unsigned NUM_STROBES = 4;

  function automatic logic [1:0] strobe_index(cmd_t c);
    return {c.io, c.wr};
  endfunction

endpackage

// File: rtl/isab_rst_sync.sv
module isab_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/isab_seq.sv
module isab_seq
  import isab_pkg::*;
#(
  parameter int unsigned MAX_WAIT = 6
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_i,
  input  logic   rdy_i,
  output phase_t phase_o,
  output logic   accept_o,
  output logic   tflag_o
);

  localparam int unsigned WCW = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);
  localparam logic [WCW-1:0] WLIM = WCW'(MAX_WAIT);

  phase_t         ph_q, ph_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic           tflag_q, tflag_d;

  always_comb begin
    ph_d    = ph_q;
    wcnt_d  = wcnt_q;
    tflag_d = tflag_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_i) begin
          ph_d    = PH_ADDR;
          wcnt_d  = '0;
          tflag_d = 1'b0;
        end
      end
      PH_ADDR: ph_d = PH_CMD;
      PH_CMD:  ph_d = PH_SAMP;
      PH_SAMP: begin
        if (rdy_i) begin
          ph_d = PH_LAST;
        end else if (MAX_WAIT == 0) begin
          ph_d    = PH_LAST;
          tflag_d = 1'b1;
        end else begin
          ph_d   = PH_WAIT;
          wcnt_d = WCW'(1);
        end
      end
      PH_WAIT: begin
        if (rdy_i) begin
          ph_d = PH_LAST;
        end else if (wcnt_q == WLIM) begin
          ph_d    = PH_LAST;
          tflag_d = 1'b1;
        end else begin
          wcnt_d = wcnt_q + WCW'(1);
        end
      end
      PH_LAST: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      wcnt_q  <= '0;
      tflag_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      wcnt_q  <= wcnt_d;
      tflag_q <= tflag_d;
    end
  end

  assign phase_o  = ph_q;
  assign accept_o = (ph_q == PH_IDLE) && req_i;
  assign tflag_o  = tflag_q;

  // R8
  wait_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= WLIM);

  // R2
  idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && req_i) |=> (ph_q == PH_ADDR));

  // R6
  ready_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SAMP && rdy_i) |=> (ph_q == PH_LAST));

  // R7
  wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SAMP && !rdy_i && MAX_WAIT > 0) |=> (ph_q == PH_WAIT));

endmodule

// File: rtl/isab_strobe.sv
module isab_strobe
  import isab_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase_i,
  input  cmd_t   cmd_i,
  output logic   ale_o,
  output logic [NUM_STROBES-1:0] strb_n_o,
  output logic   doe_o
);

  logic       cmd_active;
  logic [1:0] sel;

  assign cmd_active = (phase_i == PH_CMD) || (phase_i == PH_SAMP) ||
                      (phase_i == PH_WAIT) || (phase_i == PH_LAST);
  assign sel   = strobe_index(cmd_i);
  assign ale_o = (phase_i == PH_ADDR);
  assign doe_o = cmd_active && cmd_i.wr;

  for (genvar k = 0; k < NUM_STROBES; k++) begin : g_strb
    assign strb_n_o[k] = !(cmd_active && (sel == 2'(k)));
  end

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~strb_n_o) <= 1);

  // R3
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (&strb_n_o));

  // R9
  doe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doe_o |-> (strb_n_o[1] == 1'b0 || strb_n_o[3] == 1'b0));

endmodule

// File: rtl/isab_datapath.sv
module isab_datapath
  import isab_pkg::*;
#(
  parameter int unsigned MEM_AW = 20,
  parameter int unsigned IO_AW  = 16,
  parameter int unsigned DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase_i,
  input  logic              accept_i,
  input  logic              tflag_i,
  input  logic              wr_i,
  input  logic              io_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     bus_din_i,
  output cmd_t              cmd_o,
  output logic [MEM_AW-1:0] bus_addr_o,
  output logic [DW-1:0]     bus_dout_o,
  output logic [DW-1:0]     rdata_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              busy_o
);

  logic [MEM_AW-1:0] addr_m;
  logic [MEM_AW-1:0] addr_q, addr_d;
  logic [DW-1:0]     wd_q, wd_d;
  logic [DW-1:0]     rd_q, rd_d;
  cmd_t              cmd_q, cmd_d;
  logic              done_q, done_d;
  logic              to_q, to_d;
  logic              last;

  for (genvar b = 0; b < MEM_AW; b++) begin : g_amask
    if (b < IO_AW) begin : g_low
      assign addr_m[b] = addr_i[b];
    end else begin : g_high
      assign addr_m[b] = addr_i[b] & ~io_i;
    end
  end

  assign last = (phase_i == PH_LAST);

  always_comb begin
    addr_d = addr_q;
    wd_d   = wd_q;
    cmd_d  = cmd_q;
    rd_d   = rd_q;
    if (accept_i) begin
      addr_d = addr_m;
      wd_d   = wdata_i;
      cmd_d  = '{io: io_i, wr: wr_i};
    end
    if (last && !cmd_q.wr) rd_d = bus_din_i;
    done_d = last;
    to_d   = last && tflag_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= '0;
      cmd_q  <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      wd_q   <= wd_d;
      cmd_q  <= cmd_d;
      rd_q   <= rd_d;
      done_q <= done_d;
      to_q   <= to_d;
    end
  end

  assign busy_o     = (phase_i != PH_IDLE);
  assign bus_addr_o = busy_o ? addr_q : '0;
  assign bus_dout_o = wd_q;
  assign rdata_o    = rd_q;
  assign done_o     = done_q;
  assign timeout_o  = to_q;
  assign cmd_o      = cmd_q;

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  io_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cmd_q.io) |-> (bus_addr_o[MEM_AW-1:IO_AW] == '0));

  // R8
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> done_o);

endmodule

// File: rtl/isa_bus_master.sv
module isa_bus_master
  import isab_pkg::*;
#(
  parameter int unsigned MEM_AW   = 20,
  parameter int unsigned IO_AW    = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned MAX_WAIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              io_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [DW-1:0]     rdata_o,
  output logic [MEM_AW-1:0] bus_addr_o,
  output logic              bus_ale_o,
  output logic              bus_memr_n_o,
  output logic              bus_memw_n_o,
  output logic              bus_ior_n_o,
  output logic              bus_iow_n_o,
  output logic [DW-1:0]     bus_dout_o,
  output logic              bus_doe_o,
  input  logic [DW-1:0]     bus_din_i,
  input  logic              bus_rdy_i
);

  logic                   rst_s;
  phase_t                 phase;
  logic                   accept;
  logic                   tflag;
  cmd_t                   cmd;
  logic [NUM_STROBES-1:0] strb_n;

  isab_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  isab_seq #(.MAX_WAIT(MAX_WAIT)) u_seq (
    .clk      (clk),
    .rst_n    (rst_s),
    .req_i    (req_i),
    .rdy_i    (bus_rdy_i),
    .phase_o  (phase),
    .accept_o (accept),
    .tflag_o  (tflag)
  );

  isab_datapath #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .DW(DW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_s),
    .phase_i    (phase),
    .accept_i   (accept),
    .tflag_i    (tflag),
    .wr_i       (wr_i),
    .io_i       (io_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .bus_din_i  (bus_din_i),
    .cmd_o      (cmd),
    .bus_addr_o (bus_addr_o),
    .bus_dout_o (bus_dout_o),
    .rdata_o    (rdata_o),
    .done_o     (done_o),
    .timeout_o  (timeout_o),
    .busy_o     (busy_o)
  );

  isab_strobe u_strb (
    .clk      (clk),
    .rst_n    (rst_s),
    .phase_i  (phase),
    .cmd_i    (cmd),
    .ale_o    (bus_ale_o),
    .strb_n_o (strb_n),
    .doe_o    (bus_doe_o)
  );

  assign bus_memr_n_o = strb_n[0];
  assign bus_memw_n_o = strb_n[1];
  assign bus_ior_n_o  = strb_n[2];
  assign bus_iow_n_o  = strb_n[3];

endmodule

// File: tb/isa_bus_master_tb.sv
module isa_bus_master_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, wr_i, io_i;
  logic [19:0] addr_i;
  logic [7:0]  wdata_i;
  logic        busy_o, done_o, timeout_o;
  logic [7:0]  rdata_o;
  logic [19:0] bus_addr_o;
  logic        bus_ale_o, bus_memr_n_o, bus_memw_n_o, bus_ior_n_o, bus_iow_n_o;
  logic [7:0]  bus_dout_o;
  logic        bus_doe_o;
  logic [7:0]  bus_din_i;
  logic        bus_rdy_i;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] last_rd = 8'h00;

  always #10 clk = ~clk;

  isa_bus_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .io_i(io_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o),
    .timeout_o(timeout_o), .rdata_o(rdata_o), .bus_addr_o(bus_addr_o),
    .bus_ale_o(bus_ale_o), .bus_memr_n_o(bus_memr_n_o),
    .bus_memw_n_o(bus_memw_n_o), .bus_ior_n_o(bus_ior_n_o),
    .bus_iow_n_o(bus_iow_n_o), .bus_dout_o(bus_dout_o),
    .bus_doe_o(bus_doe_o), .bus_din_i(bus_din_i), .bus_rdy_i(bus_rdy_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] strb_now();
    return {bus_iow_n_o, bus_ior_n_o, bus_memw_n_o, bus_memr_n_o};
  endfunction

  // expected strobe vector {iow,ior,memw,memr}, active low
  function automatic logic [3:0] exp_strb(bit wr, bit io);
    logic [3:0] v = 4'hF;
    v[{io, wr}] = 1'b0;
    return v;
  endfunction

  function automatic logic [19:0] exp_addr(bit io, logic [19:0] a);
    return io ? {4'h0, a[15:0]} : a;
  endfunction

  // k = ready-low sample points; poke = raise a request mid-cycle
  task automatic run_cyc(input bit wr, input bit io, input logic [19:0] a,
                         input logic [7:0] wd, input logic [7:0] rd,
                         input int k, input bit poke);
    int nw;
    nw = (k > 6) ? 6 : k;
    req_i = 1'b1; wr_i = wr; io_i = io; addr_i = a; wdata_i = wd;
    @(negedge clk);
    req_i = 1'b0;
    // first clock: R3 R5 R11
    chk(bus_ale_o == 1'b1, "R3/R11 ale in first clock", bus_ale_o, 1);
    chk(strb_now() == 4'hF, "R3 no strobe in first clock", strb_now(), 4'hF);
    chk(bus_addr_o == exp_addr(io, a), "R5 address", bus_addr_o, exp_addr(io, a));
    @(negedge clk);
    chk(bus_ale_o == 1'b0, "R3 ale low after first clock", bus_ale_o, 0);
    chk(strb_now() == exp_strb(wr, io), "R4 strobe select", strb_now(), exp_strb(wr, io));
    chk(bus_doe_o == wr, "R9 output enable", bus_doe_o, wr);
    if (wr) chk(bus_dout_o == wd, "R9 write data", bus_dout_o, wd);
    if (poke) begin req_i = 1'b1; addr_i = ~a; end
    @(negedge clk);
    req_i = 1'b0;
    chk(bus_addr_o == exp_addr(io, a), "R2 address held", bus_addr_o, exp_addr(io, a));
    chk(strb_now() == exp_strb(wr, io), "R4 strobe third clock", strb_now(), exp_strb(wr, io));
    bus_rdy_i = (k == 0);
    for (int j = 1; j <= nw; j++) begin
      @(negedge clk);
      chk(strb_now() == exp_strb(wr, io) && !done_o && !bus_ale_o,
          "R7 wait clock strobe", strb_now(), exp_strb(wr, io));
      chk(bus_doe_o == wr, "R9 enable during wait", bus_doe_o, wr);
      bus_rdy_i = (j >= k);
    end
    @(negedge clk);
    bus_rdy_i = 1'b1;
    chk(strb_now() == exp_strb(wr, io) && !done_o, "R6 final clock", strb_now(),
        exp_strb(wr, io));
    bus_din_i = rd;
    @(negedge clk);
    if (!wr) last_rd = rd;
    chk(done_o == 1'b1, "R6/R10 done after final clock", done_o, 1);
    chk(timeout_o == (k > 6), "R8 timeout flag", timeout_o, (k > 6));
    chk(rdata_o == last_rd, "R10 read data", rdata_o, last_rd);
    chk(strb_now() == 4'hF && !busy_o, "R4 idle strobes", strb_now(), 4'hF);
    if (poke) begin
      @(negedge clk);
      chk(!busy_o && !bus_ale_o && !done_o, "R2 no extra cycle", busy_o, 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int unused_seed;
    rst_n = 1'b0; req_i = 1'b0; wr_i = 1'b0; io_i = 1'b0;
    addr_i = '0; wdata_i = '0; bus_din_i = '0; bus_rdy_i = 1'b1;
    unused_seed = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    chk(strb_now() == 4'hF && !bus_ale_o && !bus_doe_o && !busy_o && !done_o && !timeout_o,
        "R1 reset state", {strb_now(), bus_ale_o, bus_doe_o, busy_o, done_o}, 32'hF0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(strb_now() == 4'hF && !bus_ale_o && !busy_o && !done_o,
        "R1 idle after reset", {strb_now(), bus_ale_o, busy_o}, 32'h3C);

    // directed: four strobe kinds, no waits (R4 R6)
    run_cyc(0, 0, 20'hABCDE, 8'h11, 8'h5A, 0, 0);
    run_cyc(1, 0, 20'h12345, 8'hC3, 8'h00, 0, 0);
    run_cyc(0, 1, 20'hF1234, 8'h00, 8'hA5, 0, 0);
    run_cyc(1, 1, 20'hFFFFF, 8'h3C, 8'h00, 0, 0);
    @(negedge clk);
    // waits: one, exactly at cap, over cap (R7 R8)
    run_cyc(0, 0, 20'h00010, 8'h00, 8'h77, 1, 0);
    run_cyc(0, 1, 20'h80001, 8'h00, 8'h66, 6, 0);
    run_cyc(1, 0, 20'h40000, 8'h99, 8'h00, 9, 0);
    // mid-cycle request ignored (R2)
    run_cyc(0, 0, 20'h55555, 8'h00, 8'hE1, 2, 1);
    // random mix, back to back on odd draws (R11)
    for (int i = 0; i < 40; i++) begin
      bit wr, io;
      int k;
      wr = 1'($urandom);
      io = 1'($urandom);
      k  = int'($urandom_range(0, 8));
      run_cyc(wr, io, 20'($urandom), 8'($urandom), 8'($urandom), k, 0);
      if ($urandom_range(0, 1) == 0) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule